// File: doc/BRIEF.md
# Multiline Transmit Scanner

This block feeds characters to several asynchronous serial transmit lines through one shared data register. A scan pointer walks the lines in round-robin order, one position per clock. When it reaches a line that is enabled in the transmit-control mask and whose transmitter is idle, it stops there. It then raises a ready flag and shows the line number in the control/status register. Software answers with a single write to the transmit-data register. That character goes to the reported line, and the scanner moves on to the next position.

Each line holds one character at a time. After a load, the line stays busy for a fixed number of clocks, which stands in for the serializer. A busy line is passed over. An interrupt output combines the ready flag with an interrupt-enable bit. A self-timed clear operation returns the register state to idle. Scanning only runs while a scan-enable bit is set.

Register map on `reg_addr_i`: 0 is control/status, 1 is transmit-control, 2 is transmit-data.

Top module: `tx_scan_mux`

## Requirements
- R1: Bit n of the transmit-control register (address 1) enables line n. The register reads back the written mask in bits [NUM_LINES-1:0]. A line whose bit reads 0 is transmit-empty and is never loaded.
- R2: Scanning happens only while control/status bit 5 (scan enable) is 1. While that bit is 0, the ready flag (control/status bit 15) reads 0 from the cycle after it is cleared.
- R3: While not ready, the scan pointer advances one line per clock through 0..NUM_LINES-1 and wraps to 0. It stops on a line that is enabled and idle, then sets bit 15. The control/status field at bits [8 +: log2(NUM_LINES)] (bits 9:8 for 4 lines) shows the pointer's line.
- R4: While ready, with the reported line still enabled and no transmit-data write, the flag and the line field hold.
- R5: A transmit-data write (address 2) while ready delivers bits [7:0] to the reported line. On the next cycle `tx_valid_o` pulses for one cycle with `tx_line_o` and `tx_data_o`. The ready flag drops and scanning resumes at the following line.
- R6: A transmit-data write while the ready flag is 0 has no effect: `tx_valid_o` stays 0.
- R7: A loaded line keeps `line_busy_o[n]` at 1 for CHAR_CYCLES cycles and is skipped by the scanner until it is idle.
- R8: Clearing the enable bit of the line being reported drops the ready flag. The scanner then continues from the next line.
- R9: `irq_o` is 1 exactly when the ready flag and control/status bit 14 (interrupt enable) are both 1.
- R10: Writing 1 to control/status bit 4 starts a clear. Bit 4 reads 1 for CLR_CYCLES cycles, then returns to 0 by itself. The clear zeroes the transmit-control mask, bits 5 and 14, the ready flag and every line's busy state, and resets the pointer to 0. Register writes made during the clear are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Write enable for the access |
| reg_addr_i | input | 2 | Register select: 0 status, 1 mask, 2 data |
| reg_wdata_i | input | REG_W | Write data |
| reg_rdata_o | output | REG_W | Read data for the selected register (combinational) |
| irq_o | output | 1 | Transmit service request |
| tx_valid_o | output | 1 | One-cycle pulse: a character was handed to a line |
| tx_line_o | output | log2(NUM_LINES) | Line that received the character |
| tx_data_o | output | DATA_W | Character handed to the line |
| line_busy_o | output | NUM_LINES | Per-line transmitter busy |

## Verification
The scanner is first driven with all four lines enabled, which shows the round-robin order and the move to the next line after each load. Then a single line is enabled, so the busy interval alone decides when ready reappears, which separates the skip of a busy line from a plain pointer stall. A mask change while a line is reported tells the leave-on-disable rule apart from the hold-while-ready rule. Data writes with no line ready, scan enable off, interrupt enable off, and a clear with writes landing inside it each check that one input has no side effect. A cycle-level model compares every output and the read data on every clock.

// File: rtl/tx_scan_pkg.sv
package tx_scan_pkg;
  typedef enum logic [1:0] {
    REG_CSR  = 2'd0,
    REG_TCR  = 2'd1,
    REG_TDR  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  localparam int CSR_CLR_BIT  = 4;
  localparam int CSR_SCAN_BIT = 5;
  localparam int CSR_LINE_LSB = 8;
  localparam int CSR_TIE_BIT  = 14;
  localparam int CSR_RDY_BIT  = 15;
endpackage

// File: rtl/tx_line_timer.sv
module tx_line_timer #(
  parameter int CHAR_CYCLES = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic load_i,
  output logic busy_o
);
  localparam int CW = $clog2(CHAR_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (load_i)          cnt_q <= CW'(CHAR_CYCLES);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);

  AST_ONE_CHAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_o); // R7
  AST_BUSY_AFTER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i) |=> busy_o); // R7
endmodule

// File: rtl/tx_scan_core.sv
module tx_scan_core #(
  parameter int NUM_LINES = 4,
  localparam int LW = $clog2(NUM_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 scan_en_i,
  input  logic [NUM_LINES-1:0] en_i,
  input  logic [NUM_LINES-1:0] busy_i,
  input  logic                 wr_i,
  output logic                 rdy_o,
  output logic [LW-1:0]        line_o,
  output logic                 load_o
);
  logic          rdy_q;
  logic [LW-1:0] ptr_q, ptr_nxt;
  logic          cur_en, cur_busy;

  assign cur_en   = en_i[ptr_q];
  assign cur_busy = busy_i[ptr_q];
  assign ptr_nxt  = (ptr_q == LW'(NUM_LINES - 1)) ? '0 : ptr_q + LW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q <= 1'b0;
      ptr_q <= '0;
    end else if (clr_i) begin
      rdy_q <= 1'b0;
      ptr_q <= '0;
    end else if (!scan_en_i) begin
      rdy_q <= 1'b0;
    end else if (rdy_q) begin
      // leave on mask clear or after the data write
      if (!cur_en || wr_i) begin
        rdy_q <= 1'b0;
        ptr_q <= ptr_nxt;
      end
    end else if (cur_en && !cur_busy) begin
      rdy_q <= 1'b1;
    end else begin
      ptr_q <= ptr_nxt;
    end
  end

  assign rdy_o  = rdy_q;
  assign line_o = ptr_q;
  assign load_o = rdy_q && scan_en_i && !clr_i && cur_en && wr_i;

  AST_HOLD_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_q && scan_en_i && !clr_i && cur_en && !wr_i) |=> (rdy_q && $stable(ptr_q))); // R4
  AST_DROP_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_q && !cur_en) |=> !rdy_q); // R8
  AST_SCAN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scan_en_i |=> !rdy_q); // R2
  AST_READY_ON_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_q) |-> $past(en_i[ptr_q] && !busy_i[ptr_q])); // R3
endmodule

// File: rtl/tx_scan_mux.sv
module tx_scan_mux
  import tx_scan_pkg::*;
#(
  parameter int NUM_LINES   = 4,
  parameter int DATA_W      = 8,
  parameter int REG_W       = 16,
  parameter int CHAR_CYCLES = 6,
  parameter int CLR_CYCLES  = 3,
  localparam int LW = $clog2(NUM_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_req_i,
  input  logic                 reg_we_i,
  input  logic [1:0]           reg_addr_i,
  input  logic [REG_W-1:0]     reg_wdata_i,
  output logic [REG_W-1:0]     reg_rdata_o,
  output logic                 irq_o,
  output logic                 tx_valid_o,
  output logic [LW-1:0]        tx_line_o,
  output logic [DATA_W-1:0]    tx_data_o,
  output logic [NUM_LINES-1:0] line_busy_o
);
  localparam int CCW = $clog2(CLR_CYCLES + 1);

  reg_sel_e              sel;
  logic [NUM_LINES-1:0]  tcr_q;
  logic                  scan_en_q, tie_q;
  logic [CCW-1:0]        clr_cnt_q;
  logic                  clearing, wr_any, csr_wr, tcr_wr, tdr_wr;
  logic                  rdy, load;
  logic [LW-1:0]         cur_line;
  logic [NUM_LINES-1:0]  busy;
  logic                  tx_valid_q;
  logic [LW-1:0]         tx_line_q;
  logic [DATA_W-1:0]     tx_data_q;

  assign sel      = reg_sel_e'(reg_addr_i);
  assign clearing = (clr_cnt_q != '0);
  assign wr_any   = reg_req_i && reg_we_i && !clearing;
  assign csr_wr   = wr_any && (sel == REG_CSR);
  assign tcr_wr   = wr_any && (sel == REG_TCR);
  assign tdr_wr   = wr_any && (sel == REG_TDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tcr_q     <= '0;
      scan_en_q <= 1'b0;
      tie_q     <= 1'b0;
      clr_cnt_q <= '0;
    end else if (clearing) begin
      tcr_q     <= '0;
      scan_en_q <= 1'b0;
      tie_q     <= 1'b0;
      clr_cnt_q <= clr_cnt_q - CCW'(1);
    end else if (csr_wr) begin
      if (reg_wdata_i[CSR_CLR_BIT]) begin
        tcr_q     <= '0;
        scan_en_q <= 1'b0;
        tie_q     <= 1'b0;
        clr_cnt_q <= CCW'(CLR_CYCLES);
      end else begin
        scan_en_q <= reg_wdata_i[CSR_SCAN_BIT];
        tie_q     <= reg_wdata_i[CSR_TIE_BIT];
      end
    end else if (tcr_wr) begin
      tcr_q <= reg_wdata_i[NUM_LINES-1:0];
    end
  end

  tx_scan_core #(.NUM_LINES(NUM_LINES)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clearing),
    .scan_en_i (scan_en_q),
    .en_i      (tcr_q),
    .busy_i    (busy),
    .wr_i      (tdr_wr),
    .rdy_o     (rdy),
    .line_o    (cur_line),
    .load_o    (load)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    tx_line_timer #(.CHAR_CYCLES(CHAR_CYCLES)) u_timer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clearing),
      .load_i (load && (cur_line == LW'(g))),
      .busy_o (busy[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_q <= 1'b0;
      tx_line_q  <= '0;
      tx_data_q  <= '0;
    end else begin
      tx_valid_q <= load;
      if (load) begin
        tx_line_q <= cur_line;
        tx_data_q <= reg_wdata_i[DATA_W-1:0];
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (sel)
      REG_CSR: begin
        reg_rdata_o[CSR_RDY_BIT]            = rdy;
        reg_rdata_o[CSR_TIE_BIT]            = tie_q;
        reg_rdata_o[CSR_LINE_LSB +: LW]     = cur_line;
        reg_rdata_o[CSR_SCAN_BIT]           = scan_en_q;
        reg_rdata_o[CSR_CLR_BIT]            = clearing;
      end
      REG_TCR: reg_rdata_o[NUM_LINES-1:0] = tcr_q;
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o       = rdy && tie_q;
  assign tx_valid_o  = tx_valid_q;
  assign tx_line_o   = tx_line_q;
  assign tx_data_o   = tx_data_q;
  assign line_busy_o = busy;

  AST_CLR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clearing |-> !irq_o); // R10
  AST_CLR_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clearing) |-> (tcr_q == '0 && !scan_en_q && !tie_q)); // R10
  AST_TX_TO_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_valid_o) |-> busy[tx_line_o]); // R5
endmodule

// File: tb/tx_scan_mux_tb_top.sv
module tx_scan_mux_tb_top;
  localparam int NL = 4;
  localparam int CHARC = 6;
  localparam int CLRC = 3;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req = 0, we = 0;
  logic [1:0]  addr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic        irq, txv;
  logic [1:0]  txl;
  logic [7:0]  txd;
  logic [3:0]  busy;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  tx_scan_mux #(.NUM_LINES(NL), .CHAR_CYCLES(CHARC), .CLR_CYCLES(CLRC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .tx_valid_o(txv),
    .tx_line_o(txl), .tx_data_o(txd), .line_busy_o(busy));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  int m_tcr, m_mse, m_tie, m_rdy, m_ptr, m_clr, m_txv, m_txl, m_txd;
  int m_busy[NL];

  function automatic int model_read(int a);
    if (a == 0) return ((m_clr != 0) << 4) | (m_mse << 5) | (m_ptr << 8) | (m_tie << 14) | (m_rdy << 15);
    if (a == 1) return m_tcr;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tcr = 0; m_mse = 0; m_tie = 0; m_rdy = 0; m_ptr = 0; m_clr = 0;
      m_txv = 0; m_txl = 0; m_txd = 0;
      foreach (m_busy[i]) m_busy[i] = 0;
    end else begin
      bit clr_now, wr_ok, csr_w, tcr_w, tdr_w, en_p, ld;
      int nxt;
      clr_now = (m_clr != 0);
      wr_ok = req && we && !clr_now;
      csr_w = wr_ok && addr == 0;
      tcr_w = wr_ok && addr == 1;
      tdr_w = wr_ok && addr == 2;
      en_p = m_tcr[m_ptr];
      nxt = (m_ptr + 1) % NL;
      ld = !clr_now && m_mse && m_rdy && en_p && tdr_w;
      m_txv = ld;
      if (ld) begin m_txl = m_ptr; m_txd = wdata[7:0]; end
      if (!clr_now && m_mse && !m_rdy && !(en_p && m_busy[m_ptr] == 0)) begin end
      // scanner uses busy state before this edge
      if (clr_now) begin m_rdy = 0; m_ptr = 0; end
      else if (!m_mse) m_rdy = 0;
      else if (m_rdy) begin
        if (!en_p || tdr_w) begin m_rdy = 0; m_ptr = nxt; end
      end else if (en_p && m_busy[m_ptr] == 0) m_rdy = 1;
      else m_ptr = nxt;
      for (int i = 0; i < NL; i++) begin
        if (clr_now) m_busy[i] = 0;
        else if (ld && i == m_txl) m_busy[i] = CHARC;
        else if (m_busy[i] > 0) m_busy[i]--;
      end
      if (clr_now) begin m_clr--; m_tcr = 0; m_mse = 0; m_tie = 0; end
      else if (csr_w) begin
        if (wdata[4]) begin m_clr = CLRC; m_tcr = 0; m_mse = 0; m_tie = 0; end
        else begin m_mse = wdata[5]; m_tie = wdata[14]; end
      end else if (tcr_w) m_tcr = wdata[3:0];
    end
    #2;
    if (rst_n) begin
      int mb;
      mb = 0;
      for (int i = 0; i < NL; i++) if (m_busy[i] != 0) mb |= (1 << i);
      chk("R9 irq", irq, m_rdy & m_tie);
      chk("R5 tx_valid", txv, m_txv);
      if (m_txv) begin
        chk("R5 tx_line", txl, m_txl);
        chk("R5 tx_data", txd, m_txd);
      end
      chk("R7 line_busy", busy, mb);
      chk(addr == 1 ? "R1 mask readback" : "R3 status readback", rdata, model_read(addr));
    end
  end

  task automatic wr(int a, int d);
    req = 1; we = 1; addr = 2'(a); wdata = 16'(d);
    @(negedge clk);
    req = 0; we = 0; wdata = 0;
  endtask

  task automatic rd(int a, output int v);
    addr = 2'(a);
    #1;
    v = rdata;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int v;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(0, v); chk("R10 reset status", v, 0);
    rd(1, v); chk("R1 reset mask", v, 0);
    chk("R9 reset irq", irq, 0);

    // scan enable off: never ready
    wr(1, 'hF);
    wr(0, 'h4000);
    repeat (5) @(negedge clk);
    rd(0, v); chk("R2 no scan while disabled", v, 'h4000);
    chk("R2 irq idle", irq, 0);

    // enable scan: stop on line 0
    wr(0, 'h4020);
    @(negedge clk);
    rd(0, v); chk("R3 ready on line 0", v, 'hC020);
    chk("R9 irq raised", irq, 1);
    repeat (3) @(negedge clk);
    rd(0, v); chk("R4 holds on line 0", v, 'hC020);

    // load a character
    wr(2, 'h41);
    chk("R5 tx pulse", txv, 1);
    chk("R5 tx line", txl, 0);
    chk("R5 tx data", txd, 'h41);
    chk("R7 line 0 busy", busy, 'b0001);
    @(negedge clk);
    rd(0, v); chk("R5 resumes at line 1", v, 'hC120);

    // mask cleared while reporting line 1
    wr(1, 0);
    @(negedge clk);
    rd(0, v); chk("R8 leaves disabled line", v, 'h4220);
    rd(1, v); chk("R1 all lines empty", v, 0);
    wr(2, 'h55);
    chk("R6 data write ignored", txv, 0);
    @(negedge clk);
    chk("R6 no late pulse", txv, 0);

    // only line 2 enabled
    wr(1, 'h4);
    seen = 0;
    for (int i = 0; i < 12 && !seen; i++) begin
      if (irq) seen = 1; else @(negedge clk);
    end
    chk("R3 ready found", seen, 1);
    rd(0, v); chk("R3 line 2 reported", (v >> 8) & 3, 2);
    wr(2, 'h33);
    chk("R5 tx to line 2", txl, 2);
    for (int i = 0; i < CHARC - 1; i++) begin
      @(negedge clk);
      chk("R7 busy line held", busy[2], 1);
      chk("R7 busy line skipped", irq, 0);
    end
    seen = 0;
    for (int i = 0; i < 12 && !seen; i++) begin
      if (irq) seen = 1; else @(negedge clk);
    end
    chk("R7 ready after busy ends", seen, 1);
    rd(0, v); chk("R7 line 2 again", (v >> 8) & 3, 2);

    // move mask to line 3 while reporting line 2
    wr(1, 'h8);
    repeat (2) @(negedge clk);
    rd(0, v); chk("R8 moves on to line 3", v, 'hC320);

    // interrupt enable off
    wr(0, 'h0020);
    rd(0, v); chk("R9 ready kept", v, 'h8320);
    chk("R9 irq masked", irq, 0);

    // clear
    wr(0, 'h0030);
    rd(0, v); chk("R10 clear bit set", v, 'h8310);
    @(negedge clk);
    rd(0, v); chk("R10 clearing", v, 'h0010);
    wr(1, 'hF);
    rd(0, v); chk("R10 still clearing", v, 'h0010);
    @(negedge clk);
    rd(0, v); chk("R10 clear done", v, 0);
    rd(1, v); chk("R10 write during clear ignored", v, 0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule